// File: doc/BRIEF.md
# Micro-op Cracker for Register/Memory Instructions

This block sits between an instruction decoder and a load/store-style execution back end. It takes one already-decoded instruction descriptor at a time and emits the simple micro-ops that carry it out, one per cycle. The descriptor gives an operation class, an ALU function, a destination and a source register, a base register and a signed displacement for the memory operand, the address of the following instruction, and a jump target. Where an operand lives decides how many micro-ops come out. A register-only operation needs one micro-op. Each memory access adds one. CALL and RET expand into fixed multi-step sequences that work on the stack pointer.

Intermediate values live in a temporary register. Its index is one above the architectural register file, so it can never collide with a register that software sees. Both sides use valid/ready handshakes. While a sequence is in flight, the block accepts no new instruction. Downstream backpressure freezes the current micro-op in place. An out-of-range class never stalls the block: it produces a single illegal-instruction micro-op.

Top module: `uop_cracker`

## Requirements
- R1: Class 0 (register ALU) yields one micro-op of kind 2 (ALU) with fn = in_fn, dst = src1 = in_rd, src2 = in_rs.
- R2: Class 1 (memory to register) yields one kind 0 (load) with dst = in_rd, base = in_base, disp = in_disp. Class 2 (register to memory) yields one kind 1 (store) with src2 = in_rs as data, base = in_base, disp = in_disp.
- R3: Class 3 (ALU with memory source) yields two micro-ops. The first is a load into the temporary (index 16) at in_base + in_disp. The second is an ALU micro-op with fn = in_fn, dst = src1 = in_rd, src2 = 16.
- R4: Class 4 (ALU with memory destination) yields three micro-ops. The first is a load into 16 at in_base + in_disp. The second is an ALU micro-op with dst = src1 = 16, src2 = in_rs. The third is a store of src2 = 16 to the same base and disp.
- R5: Class 5 (CALL) yields four micro-ops in this order. First, kind 3 (load immediate) with dst = 16 and imm = in_nxt_pc. Second, a store of src2 = 16 with base 4 (stack pointer) and disp -4. Third, kind 4 (add immediate) with dst = src1 = 4 and imm = -4. Fourth, kind 5 (jump) with imm = in_target.
- R6: Class 6 (RET) yields three micro-ops in this order. First, a load into 16 with base 4 and disp 0. Second, kind 4 with dst = src1 = 4 and imm = +4. Third, kind 6 (indirect jump) with src1 = 16.
- R7: Class 7 yields a single kind 7 (illegal) micro-op, and the block then accepts the next instruction.
- R8: out_last is 1 on the final micro-op of each sequence and 0 on every earlier one. Every output field not named for a micro-op above reads 0.
- R9: in_ready is 0 from the cycle after an instruction is accepted until the cycle after its last micro-op is accepted, and 1 otherwise. out_valid is 1 exactly while a sequence is in flight.
- R10: While out_valid is 1 and out_ready is 0, every output holds its value, and no micro-op is skipped or repeated.
- R11: After reset, in_ready is 1 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Block can accept a descriptor |
| in_cls | input | 3 | Operation class |
| in_fn | input | FN_W | ALU function |
| in_rd | input | RW | Destination register |
| in_rs | input | RW | Source register |
| in_base | input | RW | Base register of memory operand |
| in_disp | input | DISP_W | Signed displacement |
| in_nxt_pc | input | WORD_W | Address of the following instruction |
| in_target | input | WORD_W | Jump target |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 3 | Micro-op kind |
| out_fn | output | FN_W | ALU function |
| out_dst | output | RW | Destination register |
| out_src1 | output | RW | First source register |
| out_src2 | output | RW | Second source or store data register |
| out_base | output | RW | Address base register |
| out_disp | output | DISP_W | Address displacement |
| out_imm | output | WORD_W | Immediate |
| out_last | output | 1 | Final micro-op of the instruction |

## Verification
The bound checker enforces four handshake rules on every cycle:
- a stalled micro-op stays frozen;
- input readiness is excluded while a sequence is in flight;
- a non-final accepted micro-op is always followed by another;
- jumps and illegal micro-ops always close a sequence.

The checker cannot tell which micro-op belongs to which instruction form. The exact per-form sequences, their counts and order, the temporary and stack register indices, and the reuse of the load address by the read-modify-write store are shown only by the bench. Its queue model expands each descriptor and compares every output on every cycle, both with free flow and under irregular backpressure.

// File: rtl/uc_pkg.sv
package uc_pkg;

    typedef enum logic [2:0] {
        CLS_ALU_RR = 3'd0,
        CLS_MOV_LD = 3'd1,
        CLS_MOV_ST = 3'd2,
        CLS_ALU_LD = 3'd3,
        CLS_ALU_ST = 3'd4,
        CLS_CALL   = 3'd5,
        CLS_RET    = 3'd6,
        CLS_RSVD   = 3'd7
    } cls_e;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_ALU   = 3'd2,
        K_LIMM  = 3'd3,
        K_ADDI  = 3'd4,
        K_JMP   = 3'd5,
        K_JMPR  = 3'd6,
        K_ILL   = 3'd7
    } kind_e;

endpackage

// File: rtl/uc_uop_gen.sv
module uc_uop_gen
    import uc_pkg::*;
#(
    parameter int RW      = 5,
    parameter int FN_W    = 4,
    parameter int DISP_W  = 12,
    parameter int WORD_W  = 32,
    parameter int STEP_W  = 2,
    parameter int SP_REG  = 4,
    parameter int TMP_REG = 16
) (
    input  logic [2:0]        cls,
    input  logic [STEP_W-1:0] step,
    input  logic [FN_W-1:0]   fn,
    input  logic [RW-1:0]     rd,
    input  logic [RW-1:0]     rs,
    input  logic [RW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    input  logic [WORD_W-1:0] nxt_pc,
    input  logic [WORD_W-1:0] target,
    output logic [2:0]        kind,
    output logic [FN_W-1:0]   ofn,
    output logic [RW-1:0]     dst,
    output logic [RW-1:0]     src1,
    output logic [RW-1:0]     src2,
    output logic [RW-1:0]     obase,
    output logic [DISP_W-1:0] odisp,
    output logic [WORD_W-1:0] oimm,
    output logic              last
);

    localparam int                WORD_BYTES = WORD_W / 8;
    localparam logic [RW-1:0]     TMP_IDX    = RW'(TMP_REG);
    localparam logic [RW-1:0]     SP_IDX     = RW'(SP_REG);
    localparam logic [DISP_W-1:0] PUSH_DISP  = DISP_W'(0 - WORD_BYTES);
    localparam logic [WORD_W-1:0] PUSH_ADJ   = WORD_W'(0 - WORD_BYTES);
    localparam logic [WORD_W-1:0] POP_ADJ    = WORD_W'(WORD_BYTES);
    localparam logic [STEP_W-1:0] S0         = '0;
    localparam logic [STEP_W-1:0] S1         = STEP_W'(1);
    localparam logic [STEP_W-1:0] S2         = STEP_W'(2);

    kind_e kind_c;
    assign kind = kind_c;

    always_comb begin
        kind_c = K_ILL;
        ofn    = '0;
        dst    = '0;
        src1   = '0;
        src2   = '0;
        obase  = '0;
        odisp  = '0;
        oimm   = '0;
        last   = 1'b1;
        case (cls_e'(cls))
            CLS_ALU_RR: begin
                kind_c = K_ALU;
                ofn    = fn;
                dst    = rd;
                src1   = rd;
                src2   = rs;
            end
            CLS_MOV_LD: begin
                kind_c = K_LOAD;
                dst    = rd;
                obase  = base;
                odisp  = disp;
            end
            CLS_MOV_ST: begin
                kind_c = K_STORE;
                src2   = rs;
                obase  = base;
                odisp  = disp;
            end
            CLS_ALU_LD: begin
                if (step == S0) begin
                    kind_c = K_LOAD;
                    dst    = TMP_IDX;
                    obase  = base;
                    odisp  = disp;
                    last   = 1'b0;
                end else begin
                    kind_c = K_ALU;
                    ofn    = fn;
                    dst    = rd;
                    src1   = rd;
                    src2   = TMP_IDX;
                end
            end
            CLS_ALU_ST: begin
                if (step == S0) begin
                    kind_c = K_LOAD;
                    dst    = TMP_IDX;
                    obase  = base;
                    odisp  = disp;
                    last   = 1'b0;
                end else if (step == S1) begin
                    kind_c = K_ALU;
                    ofn    = fn;
                    dst    = TMP_IDX;
                    src1   = TMP_IDX;
                    src2   = rs;
                    last   = 1'b0;
                end else begin
                    kind_c = K_STORE;
                    src2   = TMP_IDX;
                    obase  = base;
                    odisp  = disp;
                end
            end
            CLS_CALL: begin
                if (step == S0) begin
                    kind_c = K_LIMM;
                    dst    = TMP_IDX;
                    oimm   = nxt_pc;
                    last   = 1'b0;
                end else if (step == S1) begin
                    kind_c = K_STORE;
                    src2   = TMP_IDX;
                    obase  = SP_IDX;
                    odisp  = PUSH_DISP;
                    last   = 1'b0;
                end else if (step == S2) begin
                    kind_c = K_ADDI;
                    dst    = SP_IDX;
                    src1   = SP_IDX;
                    oimm   = PUSH_ADJ;
                    last   = 1'b0;
                end else begin
                    kind_c = K_JMP;
                    oimm   = target;
                end
            end
            CLS_RET: begin
                if (step == S0) begin
                    kind_c = K_LOAD;
                    dst    = TMP_IDX;
                    obase  = SP_IDX;
                    last   = 1'b0;
                end else if (step == S1) begin
                    kind_c = K_ADDI;
                    dst    = SP_IDX;
                    src1   = SP_IDX;
                    oimm   = POP_ADJ;
                    last   = 1'b0;
                end else begin
                    kind_c = K_JMPR;
                    src1   = TMP_IDX;
                end
            end
            default: begin
                kind_c = K_ILL;
            end
        endcase
    end

endmodule

// File: rtl/uc_seq_ctrl.sv
module uc_seq_ctrl #(
    parameter int RW     = 5,
    parameter int FN_W   = 4,
    parameter int DISP_W = 12,
    parameter int WORD_W = 32,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_cls,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [RW-1:0]     in_rd,
    input  logic [RW-1:0]     in_rs,
    input  logic [RW-1:0]     in_base,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [WORD_W-1:0] in_nxt_pc,
    input  logic [WORD_W-1:0] in_target,
    input  logic              out_ready,
    input  logic              step_last,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic [2:0]        cls,
    output logic [FN_W-1:0]   fn,
    output logic [RW-1:0]     rd,
    output logic [RW-1:0]     rs,
    output logic [RW-1:0]     base,
    output logic [DISP_W-1:0] disp,
    output logic [WORD_W-1:0] nxt_pc,
    output logic [WORD_W-1:0] target
);

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        logic [2:0]        cls;
        logic [FN_W-1:0]   fn;
        logic [RW-1:0]     rd;
        logic [RW-1:0]     rs;
        logic [RW-1:0]     base;
        logic [DISP_W-1:0] disp;
        logic [WORD_W-1:0] nxt_pc;
        logic [WORD_W-1:0] target;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy   = 1'b1;
                st_d.step   = '0;
                st_d.cls    = in_cls;
                st_d.fn     = in_fn;
                st_d.rd     = in_rd;
                st_d.rs     = in_rs;
                st_d.base   = in_base;
                st_d.disp   = in_disp;
                st_d.nxt_pc = in_nxt_pc;
                st_d.target = in_target;
            end
        end else if (out_ready) begin
            if (step_last) begin
                st_d.busy = 1'b0;
                st_d.step = '0;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign step   = st_q.step;
    assign cls    = st_q.cls;
    assign fn     = st_q.fn;
    assign rd     = st_q.rd;
    assign rs     = st_q.rs;
    assign base   = st_q.base;
    assign disp   = st_q.disp;
    assign nxt_pc = st_q.nxt_pc;
    assign target = st_q.target;

endmodule

// File: rtl/uop_cracker.sv
module uop_cracker #(
    parameter int NREG    = 16,
    parameter int FN_W    = 4,
    parameter int DISP_W  = 12,
    parameter int WORD_W  = 32,
    parameter int SP_REG  = 4,
    parameter int MAX_UOP = 4,
    parameter int RW      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [2:0]        in_cls,
    input  logic [FN_W-1:0]   in_fn,
    input  logic [RW-1:0]     in_rd,
    input  logic [RW-1:0]     in_rs,
    input  logic [RW-1:0]     in_base,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [WORD_W-1:0] in_nxt_pc,
    input  logic [WORD_W-1:0] in_target,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_kind,
    output logic [FN_W-1:0]   out_fn,
    output logic [RW-1:0]     out_dst,
    output logic [RW-1:0]     out_src1,
    output logic [RW-1:0]     out_src2,
    output logic [RW-1:0]     out_base,
    output logic [DISP_W-1:0] out_disp,
    output logic [WORD_W-1:0] out_imm,
    output logic              out_last
);

    localparam int STEP_W  = $clog2(MAX_UOP);
    localparam int TMP_REG = NREG;

    logic              busy;
    logic [STEP_W-1:0] step;
    logic [2:0]        cls_q;
    logic [FN_W-1:0]   fn_q;
    logic [RW-1:0]     rd_q, rs_q, base_q;
    logic [DISP_W-1:0] disp_q;
    logic [WORD_W-1:0] nxt_pc_q, target_q;
    logic              last_c;

    uc_seq_ctrl #(
        .RW(RW), .FN_W(FN_W), .DISP_W(DISP_W), .WORD_W(WORD_W), .STEP_W(STEP_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_cls(in_cls), .in_fn(in_fn), .in_rd(in_rd), .in_rs(in_rs),
        .in_base(in_base), .in_disp(in_disp), .in_nxt_pc(in_nxt_pc),
        .in_target(in_target), .out_ready(out_ready), .step_last(last_c),
        .busy(busy), .step(step), .cls(cls_q), .fn(fn_q), .rd(rd_q),
        .rs(rs_q), .base(base_q), .disp(disp_q), .nxt_pc(nxt_pc_q),
        .target(target_q)
    );

    uc_uop_gen #(
        .RW(RW), .FN_W(FN_W), .DISP_W(DISP_W), .WORD_W(WORD_W),
        .STEP_W(STEP_W), .SP_REG(SP_REG), .TMP_REG(TMP_REG)
    ) u_gen (
        .cls(cls_q), .step(step), .fn(fn_q), .rd(rd_q), .rs(rs_q),
        .base(base_q), .disp(disp_q), .nxt_pc(nxt_pc_q), .target(target_q),
        .kind(out_kind), .ofn(out_fn), .dst(out_dst), .src1(out_src1),
        .src2(out_src2), .obase(out_base), .odisp(out_disp), .oimm(out_imm),
        .last(last_c)
    );

    assign in_ready  = !busy;
    assign out_valid = busy;
    assign out_last  = last_c;

endmodule

// File: rtl/uop_cracker_chk.sv
module uop_cracker_chk #(
    parameter int RW     = 5,
    parameter int FN_W   = 4,
    parameter int DISP_W = 12,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_kind,
    input logic [FN_W-1:0]   out_fn,
    input logic [RW-1:0]     out_dst,
    input logic [RW-1:0]     out_src1,
    input logic [RW-1:0]     out_src2,
    input logic [RW-1:0]     out_base,
    input logic [DISP_W-1:0] out_disp,
    input logic [WORD_W-1:0] out_imm,
    input logic              out_last
);

    // R10: a stalled micro-op stays put
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_fn)
            && $stable(out_dst) && $stable(out_src1) && $stable(out_src2)
            && $stable(out_base) && $stable(out_disp) && $stable(out_imm)
            && $stable(out_last));

    // R9: no new instruction while a sequence is in flight
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9: taking the last micro-op frees the input side
    a_r9_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);

    // R8: a non-final micro-op is always followed by another
    a_r8_continue: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid);

    // R7: illegal micro-op stands alone
    a_r7_illegal_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 3'd7 |-> out_last);

    // R5, R6: jumps close CALL and RET sequences
    a_r5_jump_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_kind == 3'd5 || out_kind == 3'd6) |-> out_last);

endmodule

bind uop_cracker uop_cracker_chk #(
    .RW(RW), .FN_W(FN_W), .DISP_W(DISP_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_fn(out_fn),
    .out_dst(out_dst), .out_src1(out_src1), .out_src2(out_src2),
    .out_base(out_base), .out_disp(out_disp), .out_imm(out_imm),
    .out_last(out_last)
);

// File: tb/uop_cracker_test.sv
`timescale 1ns/1ps
module uop_cracker_test;

    localparam int RW = 5;
    localparam int FW = 4;
    localparam int DW = 12;
    localparam int WW = 32;
    localparam logic [RW-1:0] TMP = 5'd16;
    localparam logic [RW-1:0] SP  = 5'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_cls = '0;
    logic [FW-1:0] in_fn = '0;
    logic [RW-1:0] in_rd = '0, in_rs = '0, in_base = '0;
    logic [DW-1:0] in_disp = '0;
    logic [WW-1:0] in_nxt_pc = '0, in_target = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [2:0]    out_kind;
    logic [FW-1:0] out_fn;
    logic [RW-1:0] out_dst, out_src1, out_src2, out_base;
    logic [DW-1:0] out_disp;
    logic [WW-1:0] out_imm;
    logic          out_last;

    always #2.5 clk = ~clk;

    uop_cracker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_fn(in_fn), .in_rd(in_rd), .in_rs(in_rs),
        .in_base(in_base), .in_disp(in_disp), .in_nxt_pc(in_nxt_pc),
        .in_target(in_target), .out_valid(out_valid), .out_ready(out_ready),
        .out_kind(out_kind), .out_fn(out_fn), .out_dst(out_dst),
        .out_src1(out_src1), .out_src2(out_src2), .out_base(out_base),
        .out_disp(out_disp), .out_imm(out_imm), .out_last(out_last)
    );

    typedef struct {
        string         req;
        logic [2:0]    k;
        logic [FW-1:0] fn;
        logic [RW-1:0] d, s1, s2, b;
        logic [DW-1:0] disp;
        logic [WW-1:0] imm;
        logic          last;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    bit   stall_mode = 0;
    bit   stalled = 0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(string req, logic [2:0] k, logic [FW-1:0] fn,
                                logic [RW-1:0] d, logic [RW-1:0] s1,
                                logic [RW-1:0] s2, logic [RW-1:0] b,
                                logic [DW-1:0] disp, logic [WW-1:0] imm,
                                logic last);
        exp_t e;
        e.req = req; e.k = k; e.fn = fn; e.d = d; e.s1 = s1; e.s2 = s2;
        e.b = b; e.disp = disp; e.imm = imm; e.last = last;
        return e;
    endfunction

    // Expand the descriptor currently on the inputs into expected micro-ops
    task automatic expand();
        case (in_cls)
            3'd0: q.push_back(mk("R1", 3'd2, in_fn, in_rd, in_rd, in_rs, 0, 0, 0, 1));
            3'd1: q.push_back(mk("R2", 3'd0, 0, in_rd, 0, 0, in_base, in_disp, 0, 1));
            3'd2: q.push_back(mk("R2", 3'd1, 0, 0, 0, in_rs, in_base, in_disp, 0, 1));
            3'd3: begin
                q.push_back(mk("R3", 3'd0, 0, TMP, 0, 0, in_base, in_disp, 0, 0));
                q.push_back(mk("R3", 3'd2, in_fn, in_rd, in_rd, TMP, 0, 0, 0, 1));
            end
            3'd4: begin
                q.push_back(mk("R4", 3'd0, 0, TMP, 0, 0, in_base, in_disp, 0, 0));
                q.push_back(mk("R4", 3'd2, in_fn, TMP, TMP, in_rs, 0, 0, 0, 0));
                q.push_back(mk("R4", 3'd1, 0, 0, 0, TMP, in_base, in_disp, 0, 1));
            end
            3'd5: begin
                q.push_back(mk("R5", 3'd3, 0, TMP, 0, 0, 0, 0, in_nxt_pc, 0));
                q.push_back(mk("R5", 3'd1, 0, 0, 0, TMP, SP, 12'hFFC, 0, 0));
                q.push_back(mk("R5", 3'd4, 0, SP, SP, 0, 0, 0, 32'hFFFF_FFFC, 0));
                q.push_back(mk("R5", 3'd5, 0, 0, 0, 0, 0, 0, in_target, 1));
            end
            3'd6: begin
                q.push_back(mk("R6", 3'd0, 0, TMP, 0, 0, SP, 0, 0, 0));
                q.push_back(mk("R6", 3'd4, 0, SP, SP, 0, 0, 0, 32'd4, 0));
                q.push_back(mk("R6", 3'd6, 0, 0, TMP, 0, 0, 0, 0, 1));
            end
            default: q.push_back(mk("R7", 3'd7, 0, 0, 0, 0, 0, 0, 0, 1));
        endcase
    endtask

    task automatic compare();
        exp_t  e;
        string t;
        chk("R9", "in_ready", 64'(in_ready), 64'(q.size() == 0));
        chk("R9", "out_valid", 64'(out_valid), 64'(q.size() != 0));
        if (out_valid && q.size() != 0) begin
            e = q[0];
            t = stalled ? {"R10/", e.req} : e.req;
            chk(t, "kind", 64'(out_kind), 64'(e.k));
            chk(t, "fn", 64'(out_fn), 64'(e.fn));
            chk(t, "dst", 64'(out_dst), 64'(e.d));
            chk(t, "src1", 64'(out_src1), 64'(e.s1));
            chk(t, "src2", 64'(out_src2), 64'(e.s2));
            chk(t, "base", 64'(out_base), 64'(e.b));
            chk(t, "disp", 64'(out_disp), 64'(e.disp));
            chk(t, "imm", 64'(out_imm), 64'(e.imm));
            chk({"R8/", e.req}, "last", 64'(out_last), 64'(e.last));
        end
    endtask

    // Called at a negedge: pick out_ready, model the coming edge, check after it
    task automatic step(output bit acc);
        bit pop;
        out_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        acc = in_valid && in_ready;
        pop = out_valid && out_ready;
        stalled = out_valid && !out_ready;
        if (pop && q.size() != 0) q.delete(0);
        if (acc) expand();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(input logic [2:0] cls, input logic [FW-1:0] fn,
                         input logic [RW-1:0] rd, input logic [RW-1:0] rs,
                         input logic [RW-1:0] base, input logic [DW-1:0] disp,
                         input logic [WW-1:0] pc, input logic [WW-1:0] tgt);
        bit acc;
        in_cls = cls; in_fn = fn; in_rd = rd; in_rs = rs; in_base = base;
        in_disp = disp; in_nxt_pc = pc; in_target = tgt;
        in_valid = 1'b1;
        acc = 0;
        while (!acc) step(acc);
        in_valid = 1'b0;
        while (q.size() != 0) step(acc);
    endtask

    task automatic run_all();
        issue(3'd0, 4'd3, 5'd2, 5'd7, 5'd0, 12'h000, 0, 0);                  // R1
        issue(3'd0, 4'd15, 5'd15, 5'd0, 5'd9, 12'h123, 0, 0);                // R1
        issue(3'd1, 4'd0, 5'd3, 5'd0, 5'd5, 12'h010, 0, 0);                  // R2
        issue(3'd1, 4'd0, 5'd11, 5'd0, 5'd1, 12'hFF8, 0, 0);                 // R2 negative disp
        issue(3'd2, 4'd0, 5'd0, 5'd9, 5'd1, 12'h7FF, 0, 0);                  // R2
        issue(3'd3, 4'd1, 5'd6, 5'd0, 5'd2, 12'h004, 0, 0);                  // R3
        issue(3'd3, 4'd9, 5'd0, 5'd0, 5'd15, 12'h800, 0, 0);                 // R3
        issue(3'd4, 4'd5, 5'd0, 5'd8, 5'd3, 12'hFFC, 0, 0);                  // R4
        issue(3'd4, 4'd12, 5'd0, 5'd14, 5'd4, 12'h020, 0, 0);                // R4
        issue(3'd5, 4'd0, 5'd0, 5'd0, 5'd0, 12'h000, 32'h1000_0004, 32'h2000_0000); // R5
        issue(3'd5, 4'd7, 5'd3, 5'd3, 5'd3, 12'h555, 32'hDEAD_BEE0, 32'h0000_0040); // R5
        issue(3'd6, 4'd0, 5'd0, 5'd0, 5'd0, 12'h000, 0, 0);                  // R6
        issue(3'd7, 4'd2, 5'd1, 5'd2, 5'd3, 12'h004, 32'h1, 32'h2);          // R7
        issue(3'd0, 4'd4, 5'd1, 5'd1, 5'd0, 12'h000, 0, 0);                  // R7: block continues
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "in_ready after reset", 64'(in_ready), 64'd1);
        chk("R11", "out_valid after reset", 64'(out_valid), 64'd0);
        stall_mode = 0;
        run_all();
        stall_mode = 1;   // R10: irregular backpressure
        run_all();
        repeat (3) begin
            bit a;
            step(a);
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule